// File: doc/BRIEF.md
# Bit-Serial Register Access Slave

This block is the device-side end of a small serial register port that a host controller drives through four wires. The port has an active-low select, a serial clock, a data line from the host and a return line to the host. While select is low the host clocks one frame. A write frame carries sixteen bits that name a register and give it a new byte. A read frame carries one header byte that names a register, then eight more clock pulses during which the block returns that register's contents. Each frame has its own select pulse, and a host burst strings up to 31 of these frames together.

All three serial inputs are sampled in the system clock domain through two-stage synchronisers, and serial clock edges are found there. The register file has `NREG` eight-bit slots. Every slot is visible to neighbouring logic on a flat output bus. Slot 0 is a read-only version constant, and slots 1 to `NREG`-1 can be written. Addresses at `NREG` or above are not implemented. The meaning of each register belongs to the logic that consumes the bus.

Top module: `ser_reg_slave`

## Requirements
- R1: While select is low, the block captures data-in on each rising edge of the serial clock, most significant bit first. Clock edges that occur while select is high are ignored.
- R2: A frame whose first bit is 0 is a write of sixteen bits: bit 15 = 0, bits 14:8 = register address, bits 7:0 = data. After the sixteenth bit, an implemented writable register takes the data, and the new value appears on `regs_o` bits [8*addr+7 : 8*addr].
- R3: A frame whose first bit is 1 is a read with header bits 6:0 = address. The next eight clock pulses return the register value MSB first on `sdo`. Each bit is valid at the falling edge of its pulse and stays valid until the rising edge of the following pulse.
- R4: Address 0 always reads 0x10 and always shows 0x10 in `regs_o[7:0]`. Writes to address 0 have no effect.
- R5: Addresses from `NREG` to 127 read as 0x00. Writes to them change no register.
- R6: If select goes high before a frame is complete, the partial frame is discarded. No register changes, and the next frame is decoded from its first bit.
- R7: `sdo` is 0 while the block is deselected, while a header is arriving, and throughout a write frame.
- R8: After reset, every writable register is 0x00 and `sdo` is 0.
- R9: Frames that follow one another with only a short deselect gap, up to a burst of 31, are each decoded on their own.
- R10: Clock pulses that arrive after a frame is complete, while select is still low, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Frame select from host, active low |
| sck | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial return data to host |
| regs_o | output | NREG*8 | All register slots, slot k at bits [8k+7:8k] |

## Verification
Two events can fall in the same system cycle: the sixteenth rising clock edge that completes a write, and a select rise that ends the frame. Their order decides whether a write lands or is discarded. The bench provokes this by raising select right after frames cut short at several lengths, including one bit before the end, and it checks that the register file is unchanged and that the next frame decodes cleanly. It also places extra pulses after a complete frame before deselecting, and it checks that the written value holds and that the following read returns it.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [2:0] {
    FR_IDLE  = 3'd0,
    FR_HEAD  = 3'd1,
    FR_WDATA = 3'd2,
    FR_RDATA = 3'd3,
    FR_DONE  = 3'd4
  } fr_state_e;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int          STAGES = 2,
  parameter int          W      = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/srs_frame.sv
module srs_frame
  import srs_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_ni,
  input  logic          sck_i,
  input  logic          sdi_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          sdo_o,
  output logic          rise_o,
  output fr_state_e     state_o
);
  localparam int HB = AW + 1;          // header bits, equals DW
  localparam int FB = 2 * DW;          // bits in a full frame
  localparam int CW = $clog2(FB + 1);

  fr_state_e      st;
  logic           sck_d;
  logic [CW-1:0]  cnt;
  logic [DW-2:0]  in_sh;
  logic [DW-1:0]  out_sh;
  logic [AW-1:0]  addr_q;
  logic           rise;

  assign rise      = sck_i & ~sck_d & ~sel_ni;
  assign rd_addr_o = {in_sh[AW-2:0], sdi_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= FR_IDLE;
      sck_d     <= 1'b0;
      cnt       <= '0;
      in_sh     <= '0;
      out_sh    <= '0;
      addr_q    <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      sck_d   <= sck_i;
      wr_en_o <= 1'b0;
      if (sel_ni) begin
        st     <= FR_IDLE;
        cnt    <= '0;
        in_sh  <= '0;
        out_sh <= '0;
      end else if (rise) begin
        cnt <= cnt + 1'b1;
        unique case (st)
          FR_IDLE, FR_HEAD: begin
            in_sh <= {in_sh[DW-3:0], sdi_i};
            if (cnt == CW'(HB - 1)) begin
              if (in_sh[AW-1]) begin
                st     <= FR_RDATA;
                out_sh <= rd_data_i;
              end else begin
                st     <= FR_WDATA;
                addr_q <= rd_addr_o;
              end
            end else begin
              st <= FR_HEAD;
            end
          end
          FR_WDATA: begin
            in_sh <= {in_sh[DW-3:0], sdi_i};
            if (cnt == CW'(FB - 1)) begin
              wr_en_o   <= 1'b1;
              wr_addr_o <= addr_q;
              wr_data_o <= {in_sh, sdi_i};
              st        <= FR_DONE;
            end
          end
          FR_RDATA: begin
            if (cnt != CW'(HB)) out_sh <= {out_sh[DW-2:0], 1'b0};
            if (cnt == CW'(FB - 1)) st <= FR_DONE;
          end
          default: cnt <= cnt;
        endcase
      end else if (st == FR_IDLE) begin
        st <= FR_HEAD;
      end
    end
  end

  assign sdo_o   = ((st == FR_RDATA) || (st == FR_DONE)) & out_sh[DW-1];
  assign rise_o  = rise;
  assign state_o = st;
endmodule

// File: rtl/srs_regfile.sv
module srs_regfile #(
  parameter int          AW      = 7,
  parameter int          DW      = 8,
  parameter int          NREG    = 8,
  parameter logic [DW-1:0] VERSION = 8'h10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [NREG*DW-1:0] regs_o
);
  logic [DW-1:0] slot [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    if (i == 0) begin : g_ro
      assign slot[i] = VERSION;
    end else begin : g_rw
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  q <= '0;
        else if (wr_en_i && (wr_addr_i == AW'(i)))   q <= wr_data_i;
      end
      assign slot[i] = q;
    end
    assign regs_o[i*DW +: DW] = slot[i];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_addr_i == AW'(i)) rd_data_o = slot[i];
    end
  end
endmodule

// File: rtl/ser_reg_slave.sv
module ser_reg_slave
  import srs_pkg::*;
#(
  parameter int          AW      = 7,
  parameter int          DATA_W  = 8,
  parameter int          NREG    = 8,
  parameter int          SYNC    = 2,
  parameter logic [7:0]  VERSION = 8'h10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel_n,
  input  logic                   sck,
  input  logic                   sdi,
  output logic                   sdo,
  output logic [NREG*DATA_W-1:0] regs_o
);
  logic [2:0]        sync_q;
  logic              sel_s, sck_s, sdi_s;
  logic [AW-1:0]     rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en;
  logic              sck_rise;
  fr_state_e         fr_state;

  srs_sync #(.STAGES(SYNC), .W(3), .RST_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sel_n, sck, sdi}),
    .sync_o  (sync_q)
  );
  assign {sel_s, sck_s, sdi_s} = sync_q;

  srs_frame #(.AW(AW), .DW(DATA_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_ni    (sel_s),
    .sck_i     (sck_s),
    .sdi_i     (sdi_s),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .sdo_o     (sdo),
    .rise_o    (sck_rise),
    .state_o   (fr_state)
  );

  srs_regfile #(.AW(AW), .DW(DATA_W), .NREG(NREG), .VERSION(VERSION)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .regs_o    (regs_o)
  );
endmodule

// File: rtl/srs_chk.sv
module srs_chk
  import srs_pkg::*;
#(
  parameter int RW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_s,
  input logic          sck_rise,
  input fr_state_e     fr_state,
  input logic          wr_en,
  input logic          sdo,
  input logic [RW-1:0] regs_o
);
  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> (fr_state == FR_IDLE)); // R6

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(regs_o)); // R2

  AST_WRITE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$past(sel_s)); // R1

  AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_state == FR_IDLE || fr_state == FR_HEAD || fr_state == FR_WDATA) |-> !sdo); // R7

  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_state == FR_RDATA && !sck_rise && !sel_s) |=> $stable(sdo)); // R3
endmodule

bind ser_reg_slave srs_chk #(.RW(NREG*DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_s    (sel_s),
  .sck_rise (sck_rise),
  .fr_state (fr_state),
  .wr_en    (wr_en),
  .sdo      (sdo),
  .regs_o   (regs_o)
);

// File: tb/tb_ser_reg_slave.sv
module tb_ser_reg_slave;
  localparam int NREG = 8;
  localparam int RW   = NREG * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic sdo;
  logic [RW-1:0] regs_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [128];
  logic sdo_seen;

  always #5 clk = ~clk;

  ser_reg_slave #(.NREG(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .regs_o(regs_o)
  );

  task automatic chk(input logic ok, input string req, input logic [RW-1:0] act,
                     input logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input int a);
    if (a == 0)         return 8'h10;
    else if (a < NREG)  return model[a];
    else                return 8'h00;
  endfunction

  function automatic logic [RW-1:0] exp_regs();
    logic [RW-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = exp_read(i);
    return v;
  endfunction

  task automatic clk_bit(input logic b, output logic got);
    sdi = b;
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
    #1 got = sdo;
    repeat (3) @(negedge clk);
  endtask

  task automatic frame_on();
    sel_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame_off();
    sdi = 1'b0;
    sel_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_write(input logic [6:0] a, input logic [7:0] d, input int extra);
    logic [15:0] w;
    logic g;
    w = {1'b0, a, d};
    frame_on();
    for (int i = 15; i >= 0; i--) begin
      clk_bit(w[i], g);
      if (g) sdo_seen = 1'b1;
    end
    for (int i = 0; i < extra; i++) clk_bit(~d[i%8], g);
    frame_off();
    if (a != 0 && int'(a) < NREG) model[a] = d;
  endtask

  task automatic send_read(input logic [6:0] a, output logic [7:0] q);
    logic [7:0] h;
    logic g;
    h = {1'b1, a};
    frame_on();
    for (int i = 7; i >= 0; i--) begin
      clk_bit(h[i], g);
      if (g) sdo_seen = 1'b1;
    end
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b0, g);
      q[i] = g;
    end
    frame_off();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] q;
    logic [RW-1:0] e;
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 reset state
    chk(sdo == 1'b0, "R8 sdo after reset", RW'(sdo), '0);
    e = exp_regs();
    chk(regs_o == e, "R8 R4 regs after reset", regs_o, e);

    // R1 R2 R4 R5 R7 write sweep over every address
    sdo_seen = 1'b0;
    for (int a = 0; a < 128; a++) begin
      send_write(7'(a), 8'((a * 37 + 5) & 255), 0);
      e = exp_regs();
      chk(regs_o == e, $sformatf("R2 R4 R5 regs after write a=%0d", a), regs_o, e);
    end
    chk(sdo_seen == 1'b0, "R7 sdo during write frames", RW'(sdo_seen), '0);

    // R3 R4 R5 read sweep
    for (int a = 0; a < 128; a++) begin
      send_read(7'(a), q);
      chk(q == exp_read(a), $sformatf("R3 R4 R5 read a=%0d", a), RW'(q), RW'(exp_read(a)));
    end

    // R6 aborted frames of several lengths, then a clean frame
    for (int n = 1; n < 16; n++) begin
      logic [15:0] w;
      logic g;
      w = {1'b0, 7'd3, 8'(n * 17)};
      frame_on();
      for (int i = 15; i > 15 - n; i--) clk_bit(w[i], g);
      frame_off();
      e = exp_regs();
      chk(regs_o == e, $sformatf("R6 abort after %0d bits", n), regs_o, e);
    end
    send_read(7'd3, q);
    chk(q == model[3], "R6 read after aborts", RW'(q), RW'(model[3]));
    send_write(7'd4, 8'hA5, 0);
    e = exp_regs();
    chk(regs_o == e, "R6 write after aborts", regs_o, e);

    // R10 extra pulses after a complete frame
    send_write(7'd5, 8'h3C, 8);
    e = exp_regs();
    chk(regs_o == e, "R10 extra pulses after write", regs_o, e);
    send_read(7'd5, q);
    chk(q == 8'h3C, "R10 read back after extra pulses", RW'(q), 8'h3C);

    // R9 burst of 31 frames mixing writes and reads
    for (int k = 0; k < 31; k++) begin
      int a;
      a = 1 + (k % (NREG - 1));
      if (k % 2 == 0) begin
        send_write(7'(a), 8'((k * 53 + 11) & 255), 0);
      end else begin
        send_read(7'(a), q);
        chk(q == exp_read(a), $sformatf("R9 burst read k=%0d", k), RW'(q), RW'(exp_read(a)));
      end
    end
    e = exp_regs();
    chk(regs_o == e, "R9 regs after burst", regs_o, e);
    chk(sdo == 1'b0, "R7 sdo idle at end", RW'(sdo), '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule